// File: doc/BRIEF.md
# Peripheral Memory Clock Power-Down Register Bank

This block keeps one control bit per peripheral memory slot and drives a clock-disable line for each slot straight from that bit. Software reaches the bits through a small register port. Every 32-bit word of state has two addresses. One address sets bits: each 1 in the write data sets the matching bit. The other address clears bits: each 1 in the write data clears the matching bit. A 0 in the write data leaves the bit alone in both cases. So a single-bit change needs no read-modify-write, and two agents can never lose each other's updates.

Only privileged writes change state. Reads are open to any mode, and both addresses of a word return the same value. A 64-bit slot mask parameter marks which positions have a slave behind them. Positions without a slave ignore writes, read as 0 and drive their disable line low. After reset, every populated slot has its clock disabled.

Top module: `pd_ctrl_bank`

## Requirements
- R1: After reset, including an asynchronous reset in mid-run, each bit whose slot is present in `SLOT_MASK` is 1 (clock disabled) and every other bit is 0. `clk_dis_o` equals `SLOT_MASK`.
- R2: A privileged write to byte address 0x70 (bits 31:0) or 0x74 (bits 63:32) clears every state bit whose write-data bit is 1 and leaves bits written with 0 unchanged.
- R3: A privileged write to byte address 0x60 (bits 31:0) or 0x64 (bits 63:32) sets every state bit whose write-data bit is 1 and leaves bits written with 0 unchanged.
- R4: A read of the set address and a read of the clear address of the same word both return the current state of that word, combinationally, with 1 meaning the clock is inactive.
- R5: A write with `priv_i` = 0 changes no state bit. Reads return the state whatever the value of `priv_i`.
- R6: Bit positions that are 0 in `SLOT_MASK` always read 0, ignore set and clear writes, and hold their `clk_dis_o` line at 0.
- R7: `clk_dis_o[i]` is the registered state bit i. It changes only at the clock edge that captures a write, and never combinationally from `wdata_i` or `addr_i`.
- R8: Only the four exact byte addresses 0x60, 0x64, 0x70 and 0x74 are decoded. A read of any other address, including 0x61 or 0x68, returns 0, and a write to it changes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | ADDR_W (8) | Byte address of the access |
| wr_en_i | input | 1 | Write strobe, sampled on the rising clock edge |
| wdata_i | input | 32 | Write data; each 1 selects a bit to set or clear |
| priv_i | input | 1 | Access is privileged; writes are dropped when low |
| rdata_o | output | 32 | Read data for `addr_i`, combinational |
| clk_dis_o | output | NUM_SLOTS (64) | Per-slot clock disable, 1 = clock stopped |

## Verification
The hardest case to reach from the ports is an unpopulated position that holds its 0 under every kind of write. It must stay 0 when a set write targets it, when a clear write hits its neighbours, and when a privileged all-ones set rebuilds the whole word. The vector table reaches this case by first clearing a whole word and then writing ones into the masked holes of both words. After each of these writes a read is made through the opposite view of the same word. Directed steps then watch `clk_dis_o` on both sides of a capturing edge to show that no combinational path exists, and pulse reset in mid-run.

// File: rtl/pd_pkg.sv
package pd_pkg;
  localparam int unsigned WORD_W = 32;

  typedef enum logic [1:0] {
    ACC_NONE = 2'd0,
    ACC_SET  = 2'd1,
    ACC_CLR  = 2'd2
  } acc_e;
endpackage

// File: rtl/pd_addr_dec.sv
module pd_addr_dec
  import pd_pkg::*;
#(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned NUM_WORDS = 2,
  parameter int unsigned SET_BASE  = 'h60,
  parameter int unsigned CLR_BASE  = 'h70,
  localparam int unsigned WIDX_W   = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o,
  output acc_e              kind_o,
  output logic [WIDX_W-1:0] word_o
);
  always_comb begin
    hit_o  = 1'b0;
    kind_o = ACC_NONE;
    word_o = '0;
    for (int w = 0; w < NUM_WORDS; w++) begin
      if (addr_i == ADDR_W'(SET_BASE + 4 * w)) begin
        hit_o  = 1'b1;
        kind_o = ACC_SET;
        word_o = WIDX_W'(w);
      end
      if (addr_i == ADDR_W'(CLR_BASE + 4 * w)) begin
        hit_o  = 1'b1;
        kind_o = ACC_CLR;
        word_o = WIDX_W'(w);
      end
    end
  end
endmodule

// File: rtl/pd_word.sv
module pd_word
  import pd_pkg::*;
#(
  parameter logic [WORD_W-1:0] WORD_MASK = '1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  acc_e              kind_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic [WORD_W-1:0] state_o
);
  logic [WORD_W-1:0] sel;
  logic [WORD_W-1:0] state_q;
  logic [WORD_W-1:0] state_d;

  assign sel = wdata_i & WORD_MASK;

  always_comb begin
    state_d = state_q;
    if (we_i) begin
      unique case (kind_i)
        ACC_SET: state_d = state_q | sel;
        ACC_CLR: state_d = state_q & ~sel;
        default: state_d = state_q;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= WORD_MASK;
    else         state_q <= state_d & WORD_MASK;
  end

  assign state_o = state_q;

  assert_clr_effect_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && kind_i == ACC_CLR) |=> ((state_q & $past(wdata_i) & WORD_MASK) == '0));

  assert_set_effect_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && kind_i == ACC_SET) |=>
      ((state_q & $past(wdata_i) & WORD_MASK) == ($past(wdata_i) & WORD_MASK)));

  assert_zero_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> ((state_q & ~$past(wdata_i)) == ($past(state_q) & ~$past(wdata_i))));
endmodule

// File: rtl/pd_rd_mux.sv
module pd_rd_mux
  import pd_pkg::*;
#(
  parameter int unsigned NUM_WORDS = 2,
  localparam int unsigned WIDX_W   = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1
) (
  input  logic [NUM_WORDS*WORD_W-1:0] state_i,
  input  logic                        hit_i,
  input  logic [WIDX_W-1:0]           word_i,
  output logic [WORD_W-1:0]           rdata_o
);
  always_comb begin
    rdata_o = '0;
    for (int w = 0; w < NUM_WORDS; w++) begin
      if (hit_i && word_i == WIDX_W'(w)) rdata_o = state_i[w*WORD_W +: WORD_W];
    end
  end
endmodule

// File: rtl/pd_ctrl_bank.sv
module pd_ctrl_bank
  import pd_pkg::*;
#(
  parameter int unsigned          ADDR_W    = 8,
  parameter int unsigned          NUM_SLOTS = 64,
  parameter logic [NUM_SLOTS-1:0] SLOT_MASK = 64'h0FFF_00FF_FFFF_7FFE,
  parameter int unsigned          SET_BASE  = 'h60,
  parameter int unsigned          CLR_BASE  = 'h70,
  localparam int unsigned NUM_WORDS = (NUM_SLOTS + WORD_W - 1) / WORD_W,
  localparam int unsigned WIDX_W    = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic                 wr_en_i,
  input  logic [WORD_W-1:0]    wdata_i,
  input  logic                 priv_i,
  output logic [WORD_W-1:0]    rdata_o,
  output logic [NUM_SLOTS-1:0] clk_dis_o
);
  localparam int unsigned PAD_W = NUM_WORDS * WORD_W;
  localparam logic [PAD_W-1:0] PAD_MASK = PAD_W'(SLOT_MASK);

  logic              hit;
  acc_e              kind;
  logic [WIDX_W-1:0] word;
  logic [PAD_W-1:0]  state_all;

  pd_addr_dec #(
    .ADDR_W   (ADDR_W),
    .NUM_WORDS(NUM_WORDS),
    .SET_BASE (SET_BASE),
    .CLR_BASE (CLR_BASE)
  ) u_dec (
    .addr_i(addr_i),
    .hit_o (hit),
    .kind_o(kind),
    .word_o(word)
  );

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    logic we_w;
    assign we_w = wr_en_i & priv_i & hit & (word == WIDX_W'(w));

    pd_word #(
      .WORD_MASK(PAD_MASK[w*WORD_W +: WORD_W])
    ) u_word (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .we_i   (we_w),
      .kind_i (kind),
      .wdata_i(wdata_i),
      .state_o(state_all[w*WORD_W +: WORD_W])
    );
  end

  pd_rd_mux #(
    .NUM_WORDS(NUM_WORDS)
  ) u_rd (
    .state_i(state_all),
    .hit_i  (hit),
    .word_i (word),
    .rdata_o(rdata_o)
  );

  assign clk_dis_o = state_all[NUM_SLOTS-1:0];

  assert_unpriv_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !priv_i) |=> $stable(clk_dis_o));

  assert_idle_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(clk_dis_o));

  assert_unimpl_zero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((clk_dis_o & ~SLOT_MASK) == '0));

  assert_unmapped_rd_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit |-> (rdata_o == '0));

  assert_unmapped_wr_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !hit) |=> $stable(clk_dis_o));
endmodule

// File: tb/pd_ctrl_bank_tb.sv
module pd_ctrl_bank_tb;
  localparam int unsigned CLK_PERIOD = 10;
  localparam logic [63:0] MASK = 64'h0FFF_00FF_FFFF_7FFE;

  typedef struct packed {
    logic        wr;
    logic        priv;
    logic [7:0]  addr;
    logic [31:0] data;
    logic [31:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 28;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b1, 8'h70, 32'h0,         32'hFFFF_7FFE, 4'd1}, // R1
    '{1'b0, 1'b1, 8'h74, 32'h0,         32'h0FFF_00FF, 4'd1}, // R1
    '{1'b0, 1'b0, 8'h60, 32'h0,         32'hFFFF_7FFE, 4'd4}, // R4
    '{1'b0, 1'b0, 8'h64, 32'h0,         32'h0FFF_00FF, 4'd4}, // R4
    '{1'b1, 1'b1, 8'h70, 32'h0000_00F0, 32'h0,         4'd2}, // R2
    '{1'b0, 1'b1, 8'h70, 32'h0,         32'hFFFF_7F0E, 4'd2}, // R2
    '{1'b0, 1'b1, 8'h60, 32'h0,         32'hFFFF_7F0E, 4'd4}, // R4
    '{1'b1, 1'b1, 8'h74, 32'h0000_000F, 32'h0,         4'd2}, // R2
    '{1'b0, 1'b1, 8'h64, 32'h0,         32'h0FFF_00F0, 4'd2}, // R2
    '{1'b1, 1'b1, 8'h60, 32'h0000_0030, 32'h0,         4'd3}, // R3
    '{1'b0, 1'b1, 8'h70, 32'h0,         32'hFFFF_7F3E, 4'd3}, // R3
    '{1'b1, 1'b0, 8'h70, 32'hFFFF_FFFF, 32'h0,         4'd5}, // R5
    '{1'b0, 1'b0, 8'h70, 32'h0,         32'hFFFF_7F3E, 4'd5}, // R5
    '{1'b1, 1'b1, 8'h70, 32'hFFFF_FFFF, 32'h0,         4'd2}, // R2
    '{1'b0, 1'b1, 8'h60, 32'h0,         32'h0000_0000, 4'd2}, // R2
    '{1'b1, 1'b1, 8'h60, 32'h0000_8001, 32'h0,         4'd6}, // R6
    '{1'b0, 1'b1, 8'h70, 32'h0,         32'h0000_0000, 4'd6}, // R6
    '{1'b1, 1'b1, 8'h64, 32'hF000_FF00, 32'h0,         4'd6}, // R6
    '{1'b0, 1'b1, 8'h74, 32'h0,         32'h0FFF_00F0, 4'd6}, // R6
    '{1'b1, 1'b1, 8'h68, 32'hFFFF_FFFF, 32'h0,         4'd8}, // R8
    '{1'b1, 1'b1, 8'h61, 32'hFFFF_FFFF, 32'h0,         4'd8}, // R8
    '{1'b0, 1'b1, 8'h68, 32'h0,         32'h0000_0000, 4'd8}, // R8
    '{1'b0, 1'b1, 8'h61, 32'h0,         32'h0000_0000, 4'd8}, // R8
    '{1'b0, 1'b1, 8'h60, 32'h0,         32'h0000_0000, 4'd8}, // R8
    '{1'b1, 1'b1, 8'h64, 32'h0000_0000, 32'h0,         4'd3}, // R3
    '{1'b0, 1'b1, 8'h74, 32'h0,         32'h0FFF_00F0, 4'd3}, // R3
    '{1'b1, 1'b1, 8'h60, 32'hFFFF_FFFF, 32'h0,         4'd3}, // R3
    '{1'b0, 1'b1, 8'h70, 32'h0,         32'hFFFF_7FFE, 4'd3}  // R3
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  addr_i = '0;
  logic        wr_en_i = 1'b0;
  logic [31:0] wdata_i = '0;
  logic        priv_i = 1'b0;
  logic [31:0] rdata_o;
  logic [63:0] clk_dis_o;

  int  n_chk = 0;
  int  n_bad = 0;
  bit  done = 1'b0;

  always #(CLK_PERIOD / 2) clk_i = ~clk_i;

  pd_ctrl_bank u_dut (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .addr_i   (addr_i),
    .wr_en_i  (wr_en_i),
    .wdata_i  (wdata_i),
    .priv_i   (priv_i),
    .rdata_o  (rdata_o),
    .clk_dis_o(clk_dis_o)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [7:0] a, input logic [31:0] d, input logic p);
    @(negedge clk_i);
    addr_i = a; wdata_i = d; priv_i = p; wr_en_i = 1'b1;
    @(negedge clk_i);
    wr_en_i = 1'b0; wdata_i = '0;
  endtask

  task automatic do_read(input logic [7:0] a, input logic p, output logic [31:0] d);
    @(negedge clk_i);
    addr_i = a; priv_i = p; wr_en_i = 1'b0;
    #1 d = rdata_o;
  endtask

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge clk_i);
    check("R1 reset clk_dis_o", clk_dis_o, MASK);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R6 unimpl outputs low", clk_dis_o & ~MASK, 64'h0);

    for (int i = 0; i < NV; i++) begin
      if (VECS[i].wr) begin
        do_write(VECS[i].addr, VECS[i].data, VECS[i].priv);
      end else begin
        do_read(VECS[i].addr, VECS[i].priv, rd);
        check($sformatf("R%0d vec %0d", VECS[i].req, i), {32'h0, rd}, {32'h0, VECS[i].exp});
      end
    end

    check("R7 outputs follow state", clk_dis_o, {32'h0FFF_00F0, 32'hFFFF_7FFE});

    // R7: no combinational path; change appears after the capturing edge
    @(negedge clk_i);
    addr_i = 8'h70; wdata_i = 32'h0000_0002; priv_i = 1'b1; wr_en_i = 1'b1;
    #1 check("R7 before edge", clk_dis_o, {32'h0FFF_00F0, 32'hFFFF_7FFE});
    @(posedge clk_i);
    #1 check("R7 after edge", clk_dis_o, {32'h0FFF_00F0, 32'hFFFF_7FFC});
    @(negedge clk_i);
    wr_en_i = 1'b0;

    // R5: unprivileged set on high word leaves outputs alone
    do_write(8'h64, 32'hFFFF_FFFF, 1'b0);
    check("R5 unpriv set ignored", clk_dis_o, {32'h0FFF_00F0, 32'hFFFF_7FFC});

    // R2 high word clear seen on output
    do_write(8'h74, 32'h0FFF_0000, 1'b1);
    check("R2 hi clear output", clk_dis_o, {32'h0000_00F0, 32'hFFFF_7FFC});

    // R1 asynchronous mid-run reset
    @(negedge clk_i);
    #2 rst_ni = 1'b0;
    #1 check("R1 async reset", clk_dis_o, MASK);
    @(negedge clk_i);
    rst_ni = 1'b1;
    do_read(8'h74, 1'b0, rd);
    check("R1 read after reset", {32'h0, rd}, {32'h0, MASK[63:32]});

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule